// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block is a register-mapped general purpose I/O controller with four banks of 32 pins each (pin index p lives in bank p>>5 at bit p%32). A 32-bit register bus reaches it with a byte address, a write strobe, write data and registered read data. For every bank it holds output values, a per-pin direction and a per-pin output enable. It samples the pins through a two-flop synchronizer and drives a per-pin output value and a per-pin drive enable.

Each bank has two half-word masked-write ports. In these ports the upper 16 bits of the written word act as an active-low mask over the lower 16 bits, so one pin can be set or cleared in a single write with no read-modify-write. Each bank also has interrupt detection that can be set per pin to level or edge, rising, falling or both. A sticky status register is cleared by writing ones, and one combined interrupt output covers all banks. Bank 1 implements only its low 22 bits.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, data, direction, output enable, polarity, any-edge and status read as zero. The mask reads as the implemented bits (all masked). The type register reads 0xFFFFFFFF, except in bank 1 where it reads 0x003FFFFF. pin_out, pin_oe and irq are 0.
- R2: A write to the low masked port at byte offset 0x000+8b sets data bit i (i = 0..15) of bank b from write bit i only when write bit 16+i is 0. Every other data bit keeps its value.
- R3: A write to the high masked port at byte offset 0x004+8b sets data bit 16+i from write bit i only when write bit 16+i is 0. Every other data bit keeps its value.
- R4: The data register at 0x040+4b is read/write, and its value appears on pin_out[32b+31:32b].
- R5: Direction is at 0x204+0x40b and output enable is at 0x208+0x40b. A pin is driven (pin_oe bit 1) only when its direction bit is 1 and its enable bit is 1. pin_oe follows one cycle after the register changes.
- R6: The input register at 0x060+4b returns the pins after a two-flop synchronizer. A write to it has no effect.
- R7: Writing ones to 0x210+0x40b unmasks those pins. Writing ones to 0x214+0x40b masks them. 0x20C+0x40b reads the mask, where 1 means masked.
- R8: The status register at 0x218+0x40b is sticky and is cleared by writing ones. A bit is set by a detected event whatever the mask. Type (0x21C+0x40b) 1 means edge and 0 means level. Polarity (0x220+0x40b) 1 means rising edge or high level, and 0 means falling edge or low level. Any-edge (0x224+0x40b) 1 makes an edge pin detect both edges. A level that is still present re-sets the bit in the same cycle it is cleared.
- R9: irq is the registered OR over all banks of the status bits whose mask is 0.
- R10: Bits 22..31 of bank 1 ignore writes, read as zero, never drive pin_out or pin_oe, and never set status.
- R11: Read data is registered: it appears one cycle after the address is presented. Unmapped or misaligned addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*32 (128) | Pin input levels, asynchronous |
| pin_out | output | NUM_BANKS*32 (128) | Output value per pin |
| pin_oe | output | NUM_BANKS*32 (128) | Drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The masked ports are swept over every bank, both halves, every bit position and both values, using the single-pin pattern, starting from a non-trivial background word. The sweep tells a correct mask apart from an inverted mask, a swapped half or an update that disturbs neighbouring bits. A multi-bit mask pattern checks that masked and unmasked bits mix correctly in one write. Direction and enable use a pattern that has all four combinations, so that AND can be told apart from either input alone. Interrupt pins are driven through falling, rising, both-edge and level events, with clears during and after each event, so that sticky, re-asserting and masked behaviour are each shown separately.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int REG_W = 32;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MLO, SEL_MHI, SEL_DATA, SEL_RO,
    SEL_DIR, SEL_OEN, SEL_MASK, SEL_IEN, SEL_IDIS,
    SEL_STAT, SEL_TYPE, SEL_POL, SEL_ANY
  } reg_sel_e;

  // implemented bits of a bank; bank 1 has only 22 pins
  function automatic logic [REG_W-1:0] impl_mask(input int unsigned b);
    return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BI     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [BI-1:0]     bank
);
  always_comb begin
    sel  = SEL_NONE;
    bank = '0;
    if (addr[1:0] == 2'b00 && (addr >> 10) == 0) begin
      if (!addr[9]) begin
        if (addr[8:5] == 4'd0) begin
          sel  = addr[2] ? SEL_MHI : SEL_MLO;
          bank = addr[3 +: BI];
        end else if (addr[8:4] == 5'b00100) begin
          sel  = SEL_DATA;
          bank = addr[2 +: BI];
        end else if (addr[8:4] == 5'b00110) begin
          sel  = SEL_RO;
          bank = addr[2 +: BI];
        end
      end else if (!addr[8]) begin
        bank = addr[6 +: BI];
        case (addr[5:0])
          6'h04:   sel = SEL_DIR;
          6'h08:   sel = SEL_OEN;
          6'h0C:   sel = SEL_MASK;
          6'h10:   sel = SEL_IEN;
          6'h14:   sel = SEL_IDIS;
          6'h18:   sel = SEL_STAT;
          6'h1C:   sel = SEL_TYPE;
          6'h20:   sel = SEL_POL;
          6'h24:   sel = SEL_ANY;
          default: sel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int         W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  output logic [W-1:0] rdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] oe_q,
  output logic         pend
);
  localparam int HW = W / 2;

  logic [W-1:0]  data_q, dir_q, oen_q, mask_q, stat_q, type_q, pol_q, any_q, prev_q;
  logic [W-1:0]  s_in, evt, stat_clr, wmask;
  logic [HW-1:0] upd;

  gpio_sync #(.W(W), .STAGES(2)) u_sync (.clk(clk), .rst(rst), .d(pins), .q(s_in));

  // event detection per pin
  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (type_q[i])
        evt[i] = any_q[i] ? (s_in[i] ^ prev_q[i])
               : pol_q[i] ? (s_in[i] & ~prev_q[i]) : (~s_in[i] & prev_q[i]);
      else
        evt[i] = pol_q[i] ? s_in[i] : ~s_in[i];
    end
    evt = evt & IMPL;
  end

  assign upd      = ~wdata[W-1:HW];
  assign wmask    = wdata & IMPL;
  assign stat_clr = (wr && sel == SEL_STAT) ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; dir_q <= '0; oen_q <= '0; mask_q <= IMPL;
      stat_q <= '0; type_q <= IMPL; pol_q <= '0; any_q <= '0;
      prev_q <= '0; oe_q <= '0;
    end else begin
      prev_q <= s_in & IMPL;
      oe_q   <= dir_q & oen_q;
      stat_q <= (stat_q & ~stat_clr) | evt;
      if (wr) begin
        case (sel)
          SEL_MLO:  data_q[HW-1:0] <= ((data_q[HW-1:0] & ~upd) | (wdata[HW-1:0] & upd)) & IMPL[HW-1:0];
          SEL_MHI:  data_q[W-1:HW] <= ((data_q[W-1:HW] & ~upd) | (wdata[HW-1:0] & upd)) & IMPL[W-1:HW];
          SEL_DATA: data_q <= wmask;
          SEL_DIR:  dir_q  <= wmask;
          SEL_OEN:  oen_q  <= wmask;
          SEL_IEN:  mask_q <= mask_q & ~wmask;
          SEL_IDIS: mask_q <= mask_q | wmask;
          SEL_TYPE: type_q <= wmask;
          SEL_POL:  pol_q  <= wmask;
          SEL_ANY:  any_q  <= wmask;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA: rdata = data_q;
      SEL_RO:   rdata = s_in & IMPL;
      SEL_DIR:  rdata = dir_q;
      SEL_OEN:  rdata = oen_q;
      SEL_MASK: rdata = mask_q & IMPL;
      SEL_STAT: rdata = stat_q;
      SEL_TYPE: rdata = type_q;
      SEL_POL:  rdata = pol_q;
      SEL_ANY:  rdata = any_q;
      default:  rdata = '0;
    endcase
  end

  assign out_q = data_q;
  assign pend  = |(stat_q & ~mask_q & IMPL);

  // R2
  masked_lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_MLO) |=> ((data_q[HW-1:0] & $past(wdata[W-1:HW])) ==
                                ($past(data_q[HW-1:0]) & $past(wdata[W-1:HW]))))
    else $error("masked low write disturbed a masked bit");

  // R7
  mask_en_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_IEN) |=> ((mask_q & $past(wmask)) == '0))
    else $error("enable left a pin masked");

  // R7
  mask_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_IDIS) |=> ((~mask_q & $past(wmask)) == '0))
    else $error("disable left a pin unmasked");

  // R8
  stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_STAT) |=> ((stat_q & $past(wmask & ~evt)) == '0))
    else $error("status bit survived a clear with no event");
endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic [REG_W-1:0]             bus_wdata,
  output logic [REG_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*REG_W-1:0]   pin_in,
  output logic [NUM_BANKS*REG_W-1:0]   pin_out,
  output logic [NUM_BANKS*REG_W-1:0]   pin_oe,
  output logic                         irq
);
  localparam int BI = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  reg_sel_e              sel;
  logic [BI-1:0]         bank;
  logic [REG_W-1:0]      bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0]  pend;
  logic [REG_W-1:0]      rd_mux;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .BI(BI)) u_dec (
    .addr(bus_addr), .sel(sel), .bank(bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.W(REG_W), .IMPL(impl_mask(b))) u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr    (bus_wr && bank == BI'(b)),
      .sel   (sel),
      .wdata (bus_wdata),
      .pins  (pin_in[b*REG_W +: REG_W]),
      .rdata (bank_rd[b]),
      .out_q (pin_out[b*REG_W +: REG_W]),
      .oe_q  (pin_oe[b*REG_W +: REG_W]),
      .pend  (pend[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank == BI'(b)) rd_mux = bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq       <= |pend;
    end
  end
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
  logic         clk = 0;
  logic         rst = 1;
  logic [9:0]   bus_addr = '0;
  logic         bus_wr = 0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic         irq;

  int total = 0;
  int bad = 0;
  logic [31:0] ed [4];

  always #2.5 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [31:0] impl(input int b);
    return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a);
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, wd, m;
    wait_cyc(4);
    rst = 0;
    wait_cyc(2);

    // R1 reset state
    chk("R1 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64] | pin_out[127:96], 0);
    chk("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64] | pin_oe[127:96], 0);
    chk("R1 irq", 32'(irq), 0);
    for (int b = 0; b < 4; b++) begin
      rd('h40 + 4*b, r);      chk("R1 data", r, 0);
      rd('h204 + 'h40*b, r);  chk("R1 dir", r, 0);
      rd('h208 + 'h40*b, r);  chk("R1 oen", r, 0);
      rd('h20C + 'h40*b, r);  chk("R1 mask", r, impl(b));
      rd('h218 + 'h40*b, r);  chk("R1 stat", r, 0);
      rd('h21C + 'h40*b, r);  chk("R1 type", r, impl(b));
      rd('h220 + 'h40*b, r);  chk("R1 pol", r, 0);
      rd('h224 + 'h40*b, r);  chk("R1 any", r, 0);
    end

    // R4 and R10: full data writes
    for (int b = 0; b < 4; b++) begin
      ed[b] = 32'h5A5A_3C3C ^ (32'h1111_0000 * b) ^ 32'hC000_0000;
      wr('h40 + 4*b, ed[b]);
      ed[b] &= impl(b);
      rd('h40 + 4*b, r);
      chk(b == 1 ? "R10 data bank1" : "R4 data", r, ed[b]);
    end

    // R2 / R3 sweep: single-pin masked writes
    for (int b = 0; b < 4; b++)
      for (int h = 0; h < 2; h++)
        for (int k = 0; k < 16; k++)
          for (int v = 0; v < 2; v++) begin
            wd = (32'hFFFF_0000 ^ (32'h1_0000 << k)) | (32'(v) << k);
            wr(8*b + 4*h, wd);
            ed[b][16*h + k] = v[0];
            ed[b] &= impl(b);
            rd('h40 + 4*b, r);
            chk(h == 0 ? "R2 masked low" : "R3 masked high", r, ed[b]);
          end

    // R2 multi-bit mask pattern
    wd = 32'h00FF_1234;
    wr('h10, wd);
    m = {16'h0, ~wd[31:16]};
    ed[2] = (ed[2] & ~m) | (wd & m);
    rd('h48, r); chk("R2 multi-bit", r, ed[2]);
    wd = 32'hF0F0_ABCD;
    wr('h1C, wd);
    m = {~wd[31:16], 16'h0};
    ed[3] = (ed[3] & ~m) | ({wd[15:0], 16'h0} & m);
    rd('h4C, r); chk("R3 multi-bit", r, ed[3]);

    // R4 pin_out mirrors data
    wait_cyc(1);
    for (int b = 0; b < 4; b++) chk("R4 pin_out", pin_out[32*b +: 32], ed[b]);

    // R5 direction / enable combinations
    wr('h204 + 'h80, 32'hF0F0_F0F0);
    wr('h208 + 'h80, 32'hFF00_FF00);
    wait_cyc(2);
    chk("R5 pin_oe", pin_oe[95:64], 32'hF000_F000);
    wr('h208 + 'h80, 32'h0F0F_0F0F);
    wait_cyc(2);
    chk("R5 pin_oe swap", pin_oe[95:64], 32'h0000_0000);
    wr('h204 + 'h40, 32'hFFFF_FFFF);
    wr('h208 + 'h40, 32'hFFFF_FFFF);
    wait_cyc(2);
    chk("R10 pin_oe bank1", pin_oe[63:32], 32'h003F_FFFF);

    // R6 sampled inputs, write ignored
    pin_in[127:64] = {32'h8C31_7E02, 32'hA5C3_0F96};
    pin_in[63:32]  = 32'hFFFF_FFFF;
    wait_cyc(4);
    rd('h68, r); chk("R6 ro bank2", r, 32'hA5C3_0F96);
    rd('h6C, r); chk("R6 ro bank3", r, 32'h8C31_7E02);
    rd('h64, r); chk("R10 ro bank1", r, 32'h003F_FFFF);
    wr('h68, 32'h0000_0000);
    rd('h68, r); chk("R6 ro write ignored", r, 32'hA5C3_0F96);
    rd('h48, r); chk("R6 data untouched", r, ed[2]);

    // R11 unmapped and misaligned reads
    rd('h100, r); chk("R11 unmapped", r, 0);
    rd('h230, r); chk("R11 unmapped ctl", r, 0);
    rd('h41, r);  chk("R11 misaligned", r, 0);

    // R7 mask control on bank 0
    wr('h210, 32'h0000_000F);
    rd('h20C, r); chk("R7 enable", r, 32'hFFFF_FFF0);
    wr('h214, 32'h0000_0003);
    rd('h20C, r); chk("R7 disable", r, 32'hFFFF_FFF3);
    wr('h210, 32'h0000_0003);
    rd('h20C, r); chk("R7 re-enable", r, 32'hFFFF_FFF0);

    // R8 config: bit0 falling, bit1 rising, bit2 both, bit3 high level
    wr('h220, 32'h0000_000A);
    wr('h224, 32'h0000_0004);
    wr('h21C, 32'hFFFF_FFF7);
    wait_cyc(4);
    rd('h218, r); chk("R8 quiet", r, 0);
    chk("R9 quiet irq", 32'(irq), 0);

    pin_in[0] = 1; wait_cyc(5);
    rd('h218, r); chk("R8 rise on falling pin", r, 0);
    pin_in[0] = 0; wait_cyc(5);
    rd('h218, r); chk("R8 falling edge", r, 32'h1);
    chk("R9 irq set", 32'(irq), 1);
    wr('h218, 32'h1); wait_cyc(2);
    rd('h218, r); chk("R8 w1c", r, 0);
    chk("R9 irq cleared", 32'(irq), 0);

    pin_in[1] = 1; wait_cyc(5);
    rd('h218, r); chk("R8 rising edge", r, 32'h2);
    pin_in[2] = 1; wait_cyc(5);
    rd('h218, r); chk("R8 any edge rise", r, 32'h6);
    wr('h218, 32'h4);
    pin_in[2] = 0; wait_cyc(5);
    rd('h218, r); chk("R8 any edge fall", r, 32'h6);
    wr('h218, 32'h6); wait_cyc(1);
    rd('h218, r); chk("R8 clear two", r, 0);

    pin_in[3] = 1; wait_cyc(5);
    rd('h218, r); chk("R8 high level", r, 32'h8);
    wr('h218, 32'h8);
    rd('h218, r); chk("R8 level re-sets", r, 32'h8);
    wr('h214, 32'h8); wait_cyc(2);
    chk("R9 masked no irq", 32'(irq), 0);
    rd('h218, r); chk("R8 status while masked", r, 32'h8);
    pin_in[3] = 0; wait_cyc(5);
    wr('h218, 32'h8);
    rd('h218, r); chk("R8 level gone", r, 0);

    // R10 bank 1 upper bits never set status
    wr('h21C + 'h40, 32'h0);
    wr('h220 + 'h40, 32'hFFFF_FFFF);
    wait_cyc(4);
    rd('h218 + 'h40, r); chk("R10 stat bank1", r, 32'h003F_FFFF);
    rd('h220 + 'h40, r); chk("R10 pol bank1", r, 32'h003F_FFFF);
    chk("R9 bank1 masked irq", 32'(irq), 0);
    wr('h210 + 'h40, 32'h0040_0000);
    wait_cyc(3);
    chk("R10 unimpl enable no irq", 32'(irq), 0);
    wr('h210 + 'h40, 32'h0000_0001);
    wait_cyc(3);
    chk("R9 bank1 irq", 32'(irq), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule